// File: doc/BRIEF.md
# SD Command Path Controller

This block issues a single SD/MMC command and collects the card's reply. Software first loads a 32-bit argument and then writes a transfer word. The transfer word carries the command index, the expected response length, two check enables and a command class. Writing it starts the command. The block shifts a 48-bit frame out on the CMD line, MSB first. The frame is a start bit 0, a direction bit 1, the 6-bit index, the argument, a CRC7 over the first 40 bits, and an end bit 1.

If a response is expected, the block waits for the card's start bit and shifts in either 48 or 136 bits. It can check the received CRC and the echoed index, and it raises sticky status flags that software clears by writing 1. A long response is stored without its CRC and end bit. The 120 payload bits sit right-aligned in the 128-bit response output with a zero top byte, so software recovers the full register by shifting left 8 bits. Two busy flags report an occupied command path and a card holding DAT0 low after a busy-type command.

Every bit step waits for a strobe `sd_stb_i` that marks one SD clock period. The clock divider and the data path are outside this block.

Top module: `sd_cmd_path`

## Requirements
- R1: After a command starts, `cmd_oe_o` is high and `cmd_o` presents 48 bits MSB first: 0, 1, index[5:0], argument[31:0], CRC7, 1. The CRC7 uses x^7+x^3+1 over the first 40 bits, starting from zero. `cmd_inhibit_o` is high throughout.
- R2: The transfer word `xfer_i` has the following layout:
  - bits [1:0]: response kind (0 none, 1 long 136-bit, 2 short 48-bit, 3 short with DAT0 busy)
  - bit 2: CRC check enable
  - bit 3: index check enable
  - bits [5:4]: command class (3 = abort)
  - bits [11:6]: command index

  A write with `xfer_we_i` starts the command using the argument last loaded through `arg_we_i`.
- R3: With response kind none, the cycle after the strobe that ends the end bit sets status bit 0 (complete) and drops `cmd_inhibit_o`.
- R4: After the end bit, the block samples `cmd_i` on up to 64 strobes.
  - A low sample on any of them is taken as the response start bit.
  - If all 64 samples are high, status bit 1 (timeout) is set and the path goes idle.
- R5: After a short response, `rsp_o` holds the 32 argument bits of the response in [31:0] with zeros above, and status bit 0 is set.
- R6: After a long response, `rsp_o` holds {8'h00, response bits 8..127}. The CRC and end bit are dropped, and the CRC7 covers those 120 bits.
- R7: A received CRC mismatch sets status bit 2 only when the CRC check is enabled. The response is stored in either case.
- R8: On a short response, an index field differing from the command index sets status bit 3 only when the index check is enabled.
- R9: A kind-3 command raises `dat_inhibit_o` when it starts. The flag stays high after the response until a strobe samples `dat0_i` high.
- R10: A transfer write is ignored while `cmd_inhibit_o` is high. While `dat_inhibit_o` is high, a transfer write is ignored unless its class is abort. An accepted abort clears `dat_inhibit_o`, unless the abort is itself kind 3.
- R11: Status bits are sticky. Writing 1 to a bit of `sts_clr_i` clears that bit, and a set in the same cycle wins.
- R12: A pulse on `cmd_rst_i` returns the path to idle: `cmd_oe_o` goes low, `cmd_o` goes high, and both inhibits drop. Status is left untouched.
- R13: The frame and the response advance only on cycles with `sd_stb_i` high; without a strobe `cmd_o` holds its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sd_stb_i | input | 1 | One pulse per SD bit period |
| arg_we_i | input | 1 | Argument write strobe |
| arg_i | input | 32 | Command argument |
| xfer_we_i | input | 1 | Transfer word write strobe, starts a command |
| xfer_i | input | 12 | Transfer word (layout in R2) |
| sts_clr_i | input | 4 | Write-1-to-clear for status bits |
| cmd_rst_i | input | 1 | Command path reset pulse |
| cmd_i | input | 1 | CMD line input from card |
| dat0_i | input | 1 | DAT0 line input, low while card busy |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe_o | output | 1 | CMD line output enable |
| cmd_inhibit_o | output | 1 | Command path busy |
| dat_inhibit_o | output | 1 | Card busy on DAT0 after a busy-type command |
| sts_o | output | 4 | Sticky status: complete, timeout, CRC error, index error |
| rsp_o | output | 128 | Stored response |

## Verification
- **Sequencer state.** A corrupt bit counter or shift register shows up within one frame as a wrong bit on `cmd_o`. The bench compares all 48 bits of every issued frame against a CRC it computes itself.
- **Timeout counter.** An off-by-one in the counter shows at the 64-sample boundary as a timeout one strobe early or late. The start-bit delay is swept up to that edge.
- **Receive window.** A misplaced receive window or CRC window appears in `rsp_o` or as a spurious error flag on the cycle after the end bit.
- **Inhibit handling.** Faulty inhibit logic shows as an accepted or ignored start visible on `cmd_inhibit_o` one cycle after the write.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int ARG_W     = 32;
  localparam int IDX_W     = 6;
  localparam int CRC_W     = 7;
  localparam int XFER_W    = 12;
  localparam int STS_N     = 4;
  localparam int HDR_W     = 2 + IDX_W + ARG_W;   // bits covered by command CRC
  localparam int SHORT_LEN = HDR_W + CRC_W + 1;   // 48
  localparam int LONG_LEN  = 136;
  localparam int BODY_W    = LONG_LEN - 16;       // 120 payload bits of a long reply
  localparam int RSP_W     = 128;

  localparam int S_DONE = 0;
  localparam int S_TMO  = 1;
  localparam int S_CRC  = 2;
  localparam int S_IDX  = 3;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_LONG  = 2'd1,
    RSP_SHORT = 2'd2,
    RSP_BUSY  = 2'd3
  } rsp_kind_e;

  localparam logic [1:0] CT_ABORT = 2'b11;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [1:0]       ctype;
    logic             idx_chk;
    logic             crc_chk;
    rsp_kind_e        kind;
  } xfer_t;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX} st_e;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 #(
  parameter int          W    = 7,
  parameter logic [W-1:0] POLY = 7'h09
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb = bit_i ^ crc_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (en_i)    crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = crc_q;

  a_r7_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == '0));
endmodule

// File: rtl/sdc_flags.sv
module sdc_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign q_o[g] = q;

    a_r11_set_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> q_o[g]);
  end
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
  import sdc_pkg::*;
#(
  parameter int TMO_CYC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sd_stb_i,
  input  logic               arg_we_i,
  input  logic [ARG_W-1:0]   arg_i,
  input  logic               xfer_we_i,
  input  logic [XFER_W-1:0]  xfer_i,
  input  logic [STS_N-1:0]   sts_clr_i,
  input  logic               cmd_rst_i,
  input  logic               cmd_i,
  input  logic               dat0_i,
  output logic               cmd_o,
  output logic               cmd_oe_o,
  output logic               cmd_inhibit_o,
  output logic               dat_inhibit_o,
  output logic [STS_N-1:0]   sts_o,
  output logic [RSP_W-1:0]   rsp_o
);
  localparam int CW = 8;
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] HDR_END  = CW'(HDR_W);
  localparam logic [CW-1:0] S_LAST   = CW'(SHORT_LEN - 1);
  localparam logic [CW-1:0] L_LAST   = CW'(LONG_LEN - 1);
  localparam logic [CW-1:0] L_BODY_LO = CW'(LONG_LEN - BODY_W - 8);  // 8
  localparam logic [CW-1:0] L_BODY_END = CW'(LONG_LEN - CRC_W - 1);  // 128
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  st_e                 st_q;
  logic [CW-1:0]       cnt_q;
  logic [TW-1:0]       tcnt_q;
  logic [ARG_W-1:0]    arg_q;
  logic [HDR_W-1:0]    tx_sr_q;
  logic [BODY_W-1:0]   rx_sr_q;
  logic [RSP_W-1:0]    rsp_q;
  logic                dat_busy_q;
  rsp_kind_e           cur_kind_q;
  logic [IDX_W-1:0]    cur_idx_q;
  logic                cur_crc_q, cur_ichk_q;

  xfer_t               xw;
  logic                is_long, accept, tx_end, start_det, tmo_hit, rx_end;
  logic [CW-1:0]       rx_last, body_end;
  logic                rx_win, crc_clr, crc_en, crc_din;
  logic [CRC_W-1:0]    crc;
  logic [STS_N-1:0]    sts_set;

  assign xw       = xfer_t'(xfer_i);
  assign is_long  = (cur_kind_q == RSP_LONG);
  assign rx_last  = is_long ? L_LAST : S_LAST;
  assign body_end = is_long ? L_BODY_END : HDR_END;

  assign accept    = xfer_we_i && (st_q == ST_IDLE) && !cmd_rst_i &&
                     (!dat_busy_q || (xw.ctype == CT_ABORT));
  assign tx_end    = (st_q == ST_TX) && sd_stb_i && (cnt_q == S_LAST);
  assign start_det = (st_q == ST_WAIT) && sd_stb_i && !cmd_i;
  assign tmo_hit   = (st_q == ST_WAIT) && sd_stb_i && cmd_i && (tcnt_q == TMO_LAST);
  assign rx_end    = (st_q == ST_RX) && sd_stb_i && (cnt_q == rx_last);

  // outgoing bit: header from shift register, then CRC, then end bit
  always_comb begin
    cmd_o = 1'b1;
    if (st_q == ST_TX) begin
      if (cnt_q < HDR_END)     cmd_o = tx_sr_q[HDR_W-1];
      else if (cnt_q < S_LAST) cmd_o = crc[CRC_W-1];
    end
  end
  assign cmd_oe_o = (st_q == ST_TX);

  // CRC window on receive; feeding the received CRC drives the register to zero
  assign rx_win  = is_long ? ((cnt_q >= L_BODY_LO) && (cnt_q < L_LAST)) : (cnt_q < S_LAST);
  assign crc_clr = accept || start_det;
  assign crc_en  = sd_stb_i && (((st_q == ST_TX) && (cnt_q < S_LAST)) ||
                                ((st_q == ST_RX) && rx_win));
  assign crc_din = (st_q == ST_TX) ? cmd_o : cmd_i;

  sdc_crc7 #(.W(CRC_W), .POLY(7'h09)) i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .bit_i  (crc_din),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arg_q <= '0;
    else if (arg_we_i) arg_q <= arg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      tcnt_q     <= '0;
      tx_sr_q    <= '0;
      rx_sr_q    <= '0;
      cur_kind_q <= RSP_NONE;
      cur_idx_q  <= '0;
      cur_crc_q  <= 1'b0;
      cur_ichk_q <= 1'b0;
    end else if (cmd_rst_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q       <= ST_TX;
          cnt_q      <= '0;
          tx_sr_q    <= {2'b01, xw.idx, arg_q};
          cur_kind_q <= xw.kind;
          cur_idx_q  <= xw.idx;
          cur_crc_q  <= xw.crc_chk;
          cur_ichk_q <= xw.idx_chk;
        end
        ST_TX: if (sd_stb_i) begin
          tx_sr_q <= {tx_sr_q[HDR_W-2:0], 1'b0};
          if (cnt_q == S_LAST) begin
            st_q   <= (cur_kind_q == RSP_NONE) ? ST_IDLE : ST_WAIT;
            cnt_q  <= '0;
            tcnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: if (sd_stb_i) begin
          if (!cmd_i) begin
            st_q    <= ST_RX;
            cnt_q   <= CW'(1);
            rx_sr_q <= '0;
          end else if (tcnt_q == TMO_LAST) begin
            st_q <= ST_IDLE;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_RX: if (sd_stb_i) begin
          if (cnt_q < body_end) rx_sr_q <= {rx_sr_q[BODY_W-2:0], cmd_i};
          if (cnt_q == rx_last) st_q <= ST_IDLE;
          cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rsp_q <= '0;
    else if (rx_end && !cmd_rst_i)
      rsp_q <= is_long ? {8'h00, rx_sr_q} : {{(RSP_W-ARG_W){1'b0}}, rx_sr_q[ARG_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           dat_busy_q <= 1'b0;
    else if (cmd_rst_i || tmo_hit)         dat_busy_q <= 1'b0;
    else if (accept)                       dat_busy_q <= (xw.kind == RSP_BUSY);
    else if ((st_q == ST_IDLE) && sd_stb_i && dat0_i) dat_busy_q <= 1'b0;
  end

  always_comb begin
    sts_set         = '0;
    sts_set[S_DONE] = rx_end || (tx_end && (cur_kind_q == RSP_NONE));
    sts_set[S_TMO]  = tmo_hit;
    sts_set[S_CRC]  = rx_end && cur_crc_q && (crc != '0);
    sts_set[S_IDX]  = rx_end && cur_ichk_q && !is_long &&
                      (rx_sr_q[ARG_W +: IDX_W] != cur_idx_q);
    if (cmd_rst_i) sts_set = '0;
  end

  sdc_flags #(.N(STS_N)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sts_set),
    .clr_i  (sts_clr_i),
    .q_o    (sts_o)
  );

  assign cmd_inhibit_o = (st_q != ST_IDLE);
  assign dat_inhibit_o = dat_busy_q;
  assign rsp_o         = rsp_q;

  a_r3_end_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_inhibit_o) && !$past(cmd_rst_i) |-> (sts_o[S_DONE] || sts_o[S_TMO]));

  a_r13_hold_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX) && !sd_stb_i && !cmd_rst_i |=> $stable(cmd_o));

  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_busy_q && !dat0_i && !cmd_rst_i && !tmo_hit && !accept |=> dat_inhibit_o);

  a_r10_cmd_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) && !cmd_rst_i |=> $stable(cur_idx_q) && $stable(cur_kind_q));

  a_r4_tmo_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> (tcnt_q <= TMO_LAST));
endmodule

// File: tb/test_sd_cmd_path.sv
`timescale 1ns/1ps
module test_sd_cmd_path;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b1, arg_we = 1'b0, xfer_we = 1'b0, cmd_rst = 1'b0;
  logic cmd_in = 1'b1, dat0 = 1'b1;
  logic [31:0]  arg = '0;
  logic [11:0]  xfer = '0;
  logic [3:0]   sclr = '0;
  logic         cmd_out, cmd_oe, cinh, dinh;
  logic [3:0]   sts;
  logic [127:0] rsp;
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sd_cmd_path i_sd_cmd_path (
    .clk_i(clk), .rst_ni(rst_n), .sd_stb_i(stb), .arg_we_i(arg_we), .arg_i(arg),
    .xfer_we_i(xfer_we), .xfer_i(xfer), .sts_clr_i(sclr), .cmd_rst_i(cmd_rst),
    .cmd_i(cmd_in), .dat0_i(dat0), .cmd_o(cmd_out), .cmd_oe_o(cmd_oe),
    .cmd_inhibit_o(cinh), .dat_inhibit_o(dinh), .sts_o(sts), .rsp_o(rsp));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc_of(input logic [135:0] v, input int n);
    logic [6:0] c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [11:0] mk(input logic [5:0] idx, input logic [1:0] ct,
                                     input logic ichk, input logic cchk, input logic [1:0] kind);
    return {idx, ct, ichk, cchk, kind};
  endfunction

  function automatic logic [47:0] frame(input logic [5:0] idx, input logic [31:0] a);
    logic [39:0] h = {2'b01, idx, a};
    return {h, crc_of({96'b0, h}, 40), 1'b1};
  endfunction

  function automatic logic [135:0] rsp48(input logic [5:0] idx, input logic [31:0] a,
                                         input logic [6:0] flip);
    logic [39:0] h = {2'b00, idx, a};
    return {88'b0, h, crc_of({96'b0, h}, 40) ^ flip, 1'b1};
  endfunction

  function automatic logic [119:0] body(input logic [31:0] a);
    return {a, ~a, a ^ 32'hA5A5_5A5A, a[23:0]};
  endfunction

  function automatic logic [135:0] rsp136(input logic [119:0] b, input logic [6:0] flip);
    return {8'h3F, b, crc_of({16'b0, b}, 120) ^ flip, 1'b1};
  endfunction

  logic oe_ok;
  task automatic cmd_tx(input logic [11:0] xw, input logic [31:0] a, input int inj,
                        output logic [47:0] got);
    @(negedge clk); arg_we = 1'b1; arg = a;
    @(negedge clk); arg_we = 1'b0; xfer = xw; xfer_we = 1'b1;
    oe_ok = 1'b1;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      xfer_we = (i == inj);
      xfer = (i == inj) ? ~xw : xw;
      got[47-i] = cmd_out;
      if (!cmd_oe || !cinh) oe_ok = 1'b0;
    end
    xfer_we = 1'b0;
  endtask

  task automatic respond(input logic [135:0] bits, input int len, input int dly);
    repeat (1 + dly) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      cmd_in = bits[len-1-i];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic clr_all();
    sclr = 4'hF; @(negedge clk); sclr = 4'h0;
    @(negedge clk);
    chk("R11 w1c clears", {124'b0, sts}, 128'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset cmd_o/oe/inh", {124'b0, cmd_out, cmd_oe, cinh, dinh}, 128'h8);
    chk("R11 reset status", {124'b0, sts}, 128'h0);
    chk("R6 reset rsp", rsp, 128'h0);

    // R1 R2 R3: every index, no response
    for (int k = 0; k < 64; k++) begin
      logic [31:0] a = 32'h9E37_79B9 * (k + 1);
      cmd_tx(mk(6'(k), 2'b00, 1'b0, 1'b0, 2'd0), a, -1, got);
      chk("R1 R2 frame", {80'b0, got}, {80'b0, frame(6'(k), a)});
      chk("R1 oe and inhibit during frame", {127'b0, oe_ok}, 128'h1);
      @(negedge clk);
      chk("R3 done, idle", {123'b0, cinh, sts}, 128'h1);
      clr_all();
    end

    // R4 R5: short responses, start delay swept to the limit
    for (int k = 0; k < 16; k++) begin
      logic [5:0]  ix = 6'(k * 4 + 1);
      logic [31:0] a  = 32'h1357_9BDF * (k + 1);
      cmd_tx(mk(ix, 2'b00, 1'b1, 1'b1, 2'd2), a, -1, got);
      respond(rsp48(ix, a ^ 32'hFFFF_0000, 7'h0), 48, (k == 15) ? 63 : k * 4);
      chk("R4 R5 status", {123'b0, cinh, sts}, 128'h1);
      chk("R5 rsp", rsp, {96'b0, a ^ 32'hFFFF_0000});
      clr_all();
    end

    // R7 CRC error with and without check
    cmd_tx(mk(6'd17, 2'b00, 1'b0, 1'b1, 2'd2), 32'h1, -1, got);
    respond(rsp48(6'd17, 32'hCAFE_0001, 7'h01), 48, 2);
    chk("R7 crc err flagged", {124'b0, sts}, 128'h5);
    chk("R7 rsp stored", rsp, {96'b0, 32'hCAFE_0001});
    clr_all();
    cmd_tx(mk(6'd17, 2'b00, 1'b0, 1'b0, 2'd2), 32'h2, -1, got);
    respond(rsp48(6'd17, 32'hCAFE_0002, 7'h40), 48, 2);
    chk("R7 crc check off", {124'b0, sts}, 128'h1);
    clr_all();

    // R8 index error
    cmd_tx(mk(6'd8, 2'b00, 1'b1, 1'b1, 2'd2), 32'h3, -1, got);
    respond(rsp48(6'd9, 32'h0000_0333, 7'h0), 48, 1);
    chk("R8 idx err flagged", {124'b0, sts}, 128'h9);
    clr_all();
    cmd_tx(mk(6'd8, 2'b00, 1'b0, 1'b1, 2'd2), 32'h3, -1, got);
    respond(rsp48(6'd9, 32'h0000_0334, 7'h0), 48, 1);
    chk("R8 idx check off", {124'b0, sts}, 128'h1);
    clr_all();

    // R6 long response
    for (int k = 0; k < 4; k++) begin
      logic [119:0] b = body(32'h0F1E_2D3C * (k + 3));
      cmd_tx(mk(6'd2, 2'b00, 1'b1, 1'b1, 2'd1), 32'h0, -1, got);
      respond(rsp136(b, (k == 3) ? 7'h10 : 7'h0), 136, k);
      chk("R6 long rsp", rsp, {8'h00, b});
      chk("R6 R7 long status", {124'b0, sts}, (k == 3) ? 128'h5 : 128'h1);
      clr_all();
    end

    // R4 timeout boundary
    cmd_tx(mk(6'd55, 2'b00, 1'b0, 1'b0, 2'd2), 32'h55, -1, got);
    repeat (64) @(negedge clk);
    chk("R4 still waiting after 63 samples", {123'b0, cinh, sts}, 128'h10);
    @(negedge clk);
    chk("R4 timeout at 64", {123'b0, cinh, sts}, 128'h2);
    clr_all();

    // R9 R10 busy, ignored write, abort
    dat0 = 1'b0;
    cmd_tx(mk(6'd7, 2'b00, 1'b0, 1'b1, 2'd3), 32'h7, -1, got);
    chk("R9 dat inhibit at start", {127'b0, dinh}, 128'h1);
    respond(rsp48(6'd7, 32'h0000_0777, 7'h0), 48, 3);
    chk("R9 done, still busy", {122'b0, cinh, dinh, sts}, 128'h11);
    @(negedge clk); xfer = mk(6'd5, 2'b00, 1'b0, 1'b0, 2'd0); xfer_we = 1'b1;
    @(negedge clk); xfer_we = 1'b0;
    chk("R10 non-abort ignored while busy", {126'b0, cinh, dinh}, 128'h1);
    clr_all();
    cmd_tx(mk(6'd12, 2'b11, 1'b0, 1'b0, 2'd0), 32'h12, -1, got);
    chk("R10 abort accepted", {80'b0, got}, {80'b0, frame(6'd12, 32'h12)});
    chk("R10 abort clears dat inhibit", {127'b0, dinh}, 128'h0);
    @(negedge clk);
    chk("R3 abort done", {123'b0, cinh, sts}, 128'h1);
    clr_all();
    cmd_tx(mk(6'd7, 2'b00, 1'b0, 1'b0, 2'd3), 32'h8, -1, got);
    respond(rsp48(6'd7, 32'h8, 7'h0), 48, 0);
    repeat (4) @(negedge clk);
    chk("R9 busy while dat0 low", {127'b0, dinh}, 128'h1);
    dat0 = 1'b1;
    @(negedge clk);
    chk("R9 release on dat0 high", {127'b0, dinh}, 128'h0);
    clr_all();

    // R10 write during frame ignored
    cmd_tx(mk(6'd20, 2'b00, 1'b0, 1'b0, 2'd0), 32'h2020_2020, 10, got);
    chk("R10 frame unaffected", {80'b0, got}, {80'b0, frame(6'd20, 32'h2020_2020)});
    @(negedge clk);
    chk("R10 no second command", {123'b0, cinh, sts}, 128'h1);
    clr_all();

    // R13 strobe gating, then R12 reset mid-frame
    dat0 = 1'b0;
    xfer = mk(6'd40, 2'b00, 1'b0, 1'b0, 2'd3); xfer_we = 1'b1;
    @(negedge clk); xfer_we = 1'b0; stb = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 holds start bit", {126'b0, cmd_out, cmd_oe}, 128'h1);
    stb = 1'b1; @(negedge clk); stb = 1'b0;
    chk("R13 one step", {126'b0, cmd_out, cmd_oe}, 128'h3);
    repeat (3) @(negedge clk);
    chk("R13 holds dir bit", {126'b0, cmd_out, cmd_oe}, 128'h3);
    stb = 1'b1;
    repeat (5) @(negedge clk);
    cmd_rst = 1'b1; @(negedge clk); cmd_rst = 1'b0;
    chk("R12 cmd reset", {124'b0, cmd_out, cmd_oe, cinh, dinh}, 128'h8);
    chk("R12 status kept", {124'b0, sts}, 128'h0);
    dat0 = 1'b1;
    cmd_tx(mk(6'd33, 2'b00, 1'b0, 1'b0, 2'd0), 32'hBEEF, -1, got);
    chk("R12 usable after reset", {80'b0, got}, {80'b0, frame(6'd33, 32'hBEEF)});
    @(negedge clk);
    chk("R3 done after reset", {123'b0, cinh, sts}, 128'h1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule